// File: doc/BRIEF.md
# Aliased Bit-Update Register File

This block is a bank of 32-bit registers on a simple word-wide slave bus (address, write enable, write data, read data). Each register is reachable through four byte addresses spaced 4 bytes apart inside a 16-byte window. The low address bits choose what a write does: store the value, OR it in, clear the bits it marks, or flip the bits it marks. Software can therefore set, clear or invert single control bits in one bus write, with no read-modify-write sequence.

The word index is the byte address with its low nibble cleared, divided by four. Only every fourth word index is reachable, so the block stores just those words. A read returns the stored word on any of the four aliases. The read path is combinational, so a read that shares a cycle with a write to the same word shows the value from before the write. Accesses that are not word aligned, and accesses whose index falls past the configured depth, have no effect and read as zero. The depth is a parameter. The full-size setting covers byte offsets up to 0xC6FC, which is 0xC6FC/4 + 1 words.

Top module: `alias_regfile`

## Requirements
- R1: Synchronous active-high reset clears every register to zero. After reset, every alias of every register reads zero.
- R2: An aligned write with address bits [3:2] = 0 (offset 0x0 in the window) replaces the stored word with the write data.
- R3: An aligned write with address bits [3:2] = 1 (offset 0x4) ORs the write data into the stored word.
- R4: An aligned write with address bits [3:2] = 2 (offset 0x8) clears every stored bit that is 1 in the write data.
- R5: An aligned write with address bits [3:2] = 3 (offset 0xC) inverts every stored bit that is 1 in the write data.
- R6: The word index is (address with bits [3:0] cleared) / 4. A read ignores bits [3:2] and returns the same stored word on all four aliases.
- R7: An access with address bits [1:0] not equal to 0 is unaligned. An unaligned write changes no register, and an unaligned read returns zero.
- R8: An access whose word index is DEPTH or greater is ignored on write and returns zero on read.
- R9: Every update, including set, clear and toggle, completes at the single clock edge that samples the write. A read in the following cycle returns the new value.
- R10: A read in the same cycle as a write to the same register returns the value from before that write.
- R11: A write to one register leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address; bits [3:2] select the update operation |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Write operand |
| rd_data | output | 32 | Stored word at the addressed index, or zero for an ignored access |

## Verification
The read path and the update path share one address, so every write cycle is also a read of the same register. The bench samples the read data in each write cycle before the clock edge and expects the value from before the write. It samples again in the following cycle and expects the result of the OR, clear, toggle or store, computed by its own model. The sweep runs all four operations on every reachable register with several operand patterns. After each write it reads back all four aliases of the written register and every other register.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_STORE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } upd_op_e;

    typedef struct packed {
        logic    aligned;
        logic    in_range;
        upd_op_e op;
    } acc_info_t;

    function automatic word_t apply_op(upd_op_e op, word_t cur, word_t val);
        word_t res;
        case (op)
            OP_STORE:  res = val;
            OP_SET:    res = cur | val;
            OP_CLEAR:  res = cur & ~val;
            default:   res = cur ^ val;
        endcase
        return res;
    endfunction

    function automatic int slot_count(int depth);
        return (depth + 3) / 4;
    endfunction

endpackage

// File: rtl/alias_decode.sv
module alias_decode
    import alias_rf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 12736,
    localparam int SLOT_W = ADDR_W - 4,
    localparam int SLOTS  = slot_count(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output acc_info_t         info
);
    always_comb begin
        slot          = addr[ADDR_W-1:4];
        info.aligned  = (addr[1:0] == 2'b00);
        info.in_range = (int'(addr[ADDR_W-1:4]) < SLOTS);
        info.op       = upd_op_e'(addr[3:2]);
    end
endmodule

// File: rtl/alias_store.sv
module alias_store
    import alias_rf_pkg::*;
#(
    parameter int SLOTS  = 3184,
    parameter int SLOT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] slot,
    input  word_t             wdata,
    output word_t             rdata
);
    word_t mem [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
        end else if (we && int'(slot) < SLOTS) begin
            mem[slot] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(slot) < SLOTS) rdata = mem[slot];
    end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
    import alias_rf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 12736,
    localparam int SLOT_W = ADDR_W - 4,
    localparam int SLOTS  = slot_count(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data
);
    logic [SLOT_W-1:0] acc_slot;
    acc_info_t         acc_info;
    logic              acc_hit;
    word_t             cur_word;
    word_t             next_word;

    alias_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dec_i (
        .addr (addr),
        .slot (acc_slot),
        .info (acc_info)
    );

    assign acc_hit = acc_info.aligned && acc_info.in_range;

    alias_store #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) store_i (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && acc_hit),
        .slot  (acc_slot),
        .wdata (next_word),
        .rdata (cur_word)
    );

    always_comb begin
        next_word = apply_op(acc_info.op, cur_word, wr_data);
        rd_data   = acc_hit ? cur_word : '0;
    end
endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 12736,
    localparam int SLOTS = (DEPTH + 3) / 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data
);
    logic hit_now;
    assign hit_now = (addr[1:0] == 2'b00) && (int'(addr[ADDR_W-1:4]) < SLOTS);

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == 32'h0) else $error("reset"); // R1

    AST_STORE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_now && addr[3:2] == 2'd0) |=>
        (!hit_now || addr[ADDR_W-1:4] != $past(addr[ADDR_W-1:4]) ||
         rd_data == $past(wr_data))) else $error("store"); // R2

    AST_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_now && addr[3:2] == 2'd1) |=>
        (!hit_now || addr[ADDR_W-1:4] != $past(addr[ADDR_W-1:4]) ||
         rd_data == ($past(rd_data) | $past(wr_data)))) else $error("set"); // R3

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_now && addr[3:2] == 2'd2) |=>
        (!hit_now || addr[ADDR_W-1:4] != $past(addr[ADDR_W-1:4]) ||
         rd_data == ($past(rd_data) & ~$past(wr_data)))) else $error("clear"); // R4

    AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_now && addr[3:2] == 2'd3) |=>
        (!hit_now || addr[ADDR_W-1:4] != $past(addr[ADDR_W-1:4]) ||
         rd_data == ($past(rd_data) ^ $past(wr_data)))) else $error("toggle"); // R5

    AST_UNALIGNED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr[1:0] != 2'b00) |-> rd_data == 32'h0) else $error("unaligned"); // R7

    AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(addr[ADDR_W-1:4]) >= SLOTS) |-> rd_data == 32'h0) else $error("range"); // R8
endmodule

bind alias_regfile alias_regfile_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/alias_regfile_tb_top.sv
module alias_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 16;
    localparam int SLOTS  = 4;
    localparam int ALL_SLOTS = 1 << (ADDR_W - 4);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;

    int vectors = 0;
    int misses  = 0;
    logic [31:0] model [SLOTS];

    always #(CLK_PERIOD/2) clk = ~clk;

    alias_regfile #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive after falling edge, sample the combinational read, then commit
    task automatic access(logic [ADDR_W-1:0] a, logic we, logic [31:0] d,
                          output logic [31:0] seen);
        @(negedge clk);
        addr = a; wr_en = we; wr_data = d;
        #2 seen = rd_data;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic read_check(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
        logic [31:0] v;
        access(a, 1'b0, 32'h0, v);
        check(tag, v, exp);
    endtask

    function automatic logic [31:0] pattern(int a, int b, int c);
        return (32'(a) * 32'h0101_0F1F) ^ (32'(b) * 32'h2233_4455) ^
               (32'(c + 1) * 32'h9E37_79B9);
    endfunction

    function automatic logic [31:0] expect_op(int op, logic [31:0] cur, logic [31:0] v);
        case (op)
            0: return v;
            1: return cur | v;
            2: return cur & ~v;
            default: return cur ^ v;
        endcase
    endfunction

    task automatic verify_all(string tag);
        for (int s = 0; s < SLOTS; s++)
            read_check(ADDR_W'(s * 16), model[s], tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [31:0] seen;
        for (int s = 0; s < SLOTS; s++) model[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: every alias of every register reads zero after reset
        for (int s = 0; s < SLOTS; s++)
            for (int o = 0; o < 4; o++)
                read_check(ADDR_W'(s * 16 + o * 4), 32'h0, "R1");

        // R2..R5, R9, R10, R6, R11 sweep
        for (int s = 0; s < SLOTS; s++) begin
            for (int op = 0; op < 4; op++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [31:0] d;
                    logic [31:0] nv;
                    d  = pattern(s, op, k);
                    nv = expect_op(op, model[s], d);
                    access(ADDR_W'(s * 16 + op * 4), 1'b1, d, seen);
                    check("R10", seen, model[s]);
                    model[s] = nv;
                    case (op)
                        0: read_check(ADDR_W'(s * 16), nv, "R2 R9");
                        1: read_check(ADDR_W'(s * 16), nv, "R3 R9");
                        2: read_check(ADDR_W'(s * 16), nv, "R4 R9");
                        default: read_check(ADDR_W'(s * 16), nv, "R5 R9");
                    endcase
                    for (int o = 1; o < 4; o++)
                        read_check(ADDR_W'(s * 16 + o * 4), nv, "R6");
                    for (int t = 0; t < SLOTS; t++)
                        if (t != s) read_check(ADDR_W'(t * 16), model[t], "R11");
                end
            end
        end

        // R7: unaligned writes change nothing, unaligned reads return zero
        for (int s = 0; s < SLOTS; s++)
            for (int o = 0; o < 4; o++)
                for (int b = 1; b < 4; b++) begin
                    access(ADDR_W'(s * 16 + o * 4 + b), 1'b1, 32'hFFFF_FFFF, seen);
                    check("R7", seen, 32'h0);
                end
        verify_all("R7");

        // R8: indices at or past DEPTH are ignored and read zero
        for (int s = SLOTS; s < ALL_SLOTS; s++)
            for (int o = 0; o < 4; o++) begin
                access(ADDR_W'(s * 16 + o * 4), 1'b1, 32'hDEAD_BEEF, seen);
                check("R8", seen, 32'h0);
                read_check(ADDR_W'(s * 16 + o * 4), 32'h0, "R8");
            end
        verify_all("R8");

        // R1: a second reset clears the registers again
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
        for (int s = 0; s < SLOTS; s++) model[s] = '0;
        verify_all("R1");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule